// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block holds the time of day and the calendar as packed BCD bytes: seconds, minutes, hours, day of week, date, month (with a century flag) and a two-digit year. It is fed with a clock-enable pulse at 32.768 kHz. A prescaler of `PRESC_W` bits (15 by default) divides that enable down to one advance per second, and the advance ripples through the fields with the correct month lengths and leap years.

Software loads any field through a one-byte write port. A write to the seconds field also restarts the prescaler, so the next second boundary comes a full second after that write. The hours byte carries its own mode bit. It is read either as a 24-hour value or as a 12-hour value with a PM flag. The most significant prescaler bit is brought out as a 1 Hz phase signal, and a halt input freezes the whole chain.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 00 (24-hour mode), day of week 1, date 01, month 01 with the century bit clear, year 00, and the phase output low.
- R2: Seconds and minutes count in BCD from 00 to 59. Leaving 59 returns the field to 00 and carries into the next field.
- R3: When hours bit 6 is 0, hours bits 5:0 hold a BCD value from 00 to 23. Leaving 23:59:59 gives 00:00:00 and advances the calendar by one day.
- R4: When hours bit 6 is 1, bit 5 is the PM flag (1 = PM) and bits 4:0 hold a BCD value from 01 to 12. The hour 11 goes to 12 and toggles the flag, and 12 goes to 01 with the flag kept. The change from 11 PM to 12 AM advances the calendar by one day.
- R5: The date counts in BCD from 01. It wraps to 01 and advances the month after day 30 of April, June, September and November, and after day 31 of the other months apart from February.
- R6: February ends after day 29 when the year, read as a binary number made of its two BCD digits, is divisible by 4. Otherwise it ends after day 28.
- R7: The month (bits 4:0) runs from 01 to 12. Leaving 12 gives 01 and advances the year. A year change from 99 to 00 toggles the century flag in bit 7 of the month byte.
- R8: The day of week (1 to 7) advances at each calendar day advance and wraps from 7 to 1.
- R9: A write with field code 0 = seconds, 1 = minutes, 2 = hours, 3 = day of week, 4 = date, 5 = month, 6 = year loads that byte, and the output shows it from the next cycle. Unused bits read as 0.
- R10: A seconds write clears the prescaler. The next seconds advance comes after exactly 2^PRESC_W enable pulses that follow the write.
- R11: The phase output is low after a seconds write. It goes high after 2^(PRESC_W-1) enable pulses, that is half a second later, while the oscillator runs.
- R12: While the halt input is 1, the prescaler and every field hold their value except for writes, and the phase output does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_tick_i | input | 1 | 32.768 kHz clock-enable pulse |
| osc_halt_i | input | 1 | 1 freezes the prescaler and counting |
| wr_en_i | input | 1 | Field write strobe |
| wr_field_i | input | 3 | Field code of the write (R9) |
| wr_data_i | input | 8 | BCD byte to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours: bit 6 mode, bit 5 PM or tens, BCD |
| wday_o | output | 8 | Day of week 1 to 7 |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Bit 7 century flag, bits 4:0 month BCD |
| year_o | output | 8 | Year, BCD |
| half_sec_o | output | 1 | 1 Hz phase, the prescaler MSB |

## Verification
A write appears on the outputs in the cycle after its strobe edge. A seconds advance, and the carries that ripple from it, lands on the edge that counts the 2^PRESC_W-th enable pulse after the last seconds write. The phase output rises on the edge that counts the 2^(PRESC_W-1)-th pulse. The bench uses a 3-bit prescaler and holds the enable low while it loads a starting time. It writes seconds last and only then raises the enable, so every expected second lands exactly eight falling edges after the previous one, and the outputs are sampled at those falling edges. The expected values come from an integer model of time and date that the bench converts to BCD.

// File: rtl/cal_pkg.sv
// Shared field codes and BCD helpers for the calendar clock.
// Assumes all operands are packed BCD bytes.
package cal_pkg;

    // Field selector codes on the write port
    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6
    } field_e;

    // Increment a packed BCD byte by one (no range wrap)
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last BCD date of a month; leap test uses (2*tens + units) mod 4
    function automatic logic [5:0] month_days(input logic [4:0] mon,
                                              input logic       tens_lsb,
                                              input logic [1:0] units_lo);
        logic [1:0] rem4;
        rem4 = {tens_lsb, 1'b0} + units_lo;
        case (mon)
            5'h02:                      return (rem4 == 2'd0) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// Sub-second divider: counts clock-enable pulses while running and
// emits a one-cycle second strobe when it wraps. Clear has priority.
// Assumes tick_i is a single-cycle enable.
module cal_prescaler #(
    parameter int W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic clear_i,
    output logic sec_tick_o,
    output logic phase_o
);
    localparam logic [W-1:0] LAST = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Divider count: reset/clear to zero, advance on enabled ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear_i)
            cnt_q <= '0;
        else if (tick_i && run_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // Second strobe on the wrapping tick, phase is the count MSB
    always_comb begin
        sec_tick_o = tick_i && run_i && !clear_i && (cnt_q == LAST);
        phase_o    = cnt_q[W-1];
    end
endmodule

// File: rtl/cal_sexa_counter.sv
// Loadable BCD counter 00..59 used for seconds and minutes.
// Values at or above 59 wrap to 00 so illegal loads cannot lock it.
module cal_sexa_counter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc_i,
    input  logic       load_i,
    input  logic [6:0] load_val_i,
    output logic [6:0] val_o,
    output logic       at_end_o
);
    import cal_pkg::*;

    logic [6:0] val_q;

    // Counter register: load wins over increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= 7'h00;
        else if (load_i)
            val_q <= load_val_i;
        else if (inc_i)
            val_q <= at_end_o ? 7'h00 : 7'(bcd_step(8'(val_q)));
    end

    // End-of-range flag drives the carry to the next field
    always_comb begin
        at_end_o = (val_q >= 7'h59);
        val_o    = val_q;
    end
endmodule

// File: rtl/cal_time_of_day.sv
// Seconds, minutes and hours with 12/24-hour hour encoding.
// Produces a day-advance strobe at midnight in either mode.
module cal_time_of_day (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_field_i,
    input  logic [6:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic       day_adv_o
);
    import cal_pkg::*;

    localparam int NSEXA = 2;

    logic [NSEXA-1:0] sx_inc, sx_load, sx_end;
    logic [6:0]       sx_val [NSEXA];
    logic [6:0]       hr_q, hr_n;
    logic             hour_adv, hour_end;

    // Seconds (index 0) and minutes (index 1) share one counter type
    for (genvar i = 0; i < NSEXA; i++) begin : g_sexa
        localparam field_e FLD = (i == 0) ? FLD_SEC : FLD_MIN;
        if (i == 0) begin : g_first
            assign sx_inc[i] = step_i;
        end else begin : g_next
            assign sx_inc[i] = step_i && (&sx_end[i-1:0]);
        end
        assign sx_load[i] = wr_en_i && (wr_field_i == FLD);
        cal_sexa_counter u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (sx_inc[i]),
            .load_i    (sx_load[i]),
            .load_val_i(wr_data_i),
            .val_o     (sx_val[i]),
            .at_end_o  (sx_end[i])
        );
    end

    // Next hour value in the current mode and the midnight condition
    always_comb begin
        hour_adv = step_i && (&sx_end);
        hr_n     = hr_q;
        if (hr_q[6]) begin
            if (hr_q[4:0] >= 5'h12)
                hr_n = {hr_q[6:5], 5'h01};
            else if (hr_q[4:0] == 5'h11)
                hr_n = {1'b1, ~hr_q[5], 5'h12};
            else
                hr_n = {hr_q[6:5], 5'(bcd_step(8'(hr_q[4:0])))};
            hour_end = hr_q[5] && (hr_q[4:0] == 5'h11);
        end else begin
            if (hr_q[5:0] >= 6'h23)
                hr_n = 7'h00;
            else
                hr_n = {1'b0, 6'(bcd_step(8'(hr_q[5:0])))};
            hour_end = (hr_q[5:0] >= 6'h23);
        end
        day_adv_o = hour_adv && hour_end;
    end

    // Hours register: write wins over advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            hr_q <= 7'h00;
        else if (wr_en_i && (wr_field_i == FLD_HOUR))
            hr_q <= wr_data_i;
        else if (hour_adv)
            hr_q <= hr_n;
    end

    // Zero-extended output bytes
    always_comb begin
        sec_o  = {1'b0, sx_val[0]};
        min_o  = {1'b0, sx_val[1]};
        hour_o = {1'b0, hr_q};
    end
endmodule

// File: rtl/cal_date.sv
// Day of week, date, month with century flag, and year.
// Advances on the day strobe; month length and leap years from cal_pkg.
module cal_date (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_field_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    import cal_pkg::*;

    logic [2:0] wday_q;
    logic [5:0] date_q;
    logic [4:0] mon_q;
    logic       cent_q;
    logic [7:0] year_q;
    logic       date_end, mon_adv, mon_end, year_adv, year_end;

    // Carry chain through date, month and year
    always_comb begin
        date_end = (date_q >= month_days(mon_q, year_q[4], year_q[1:0]));
        mon_adv  = day_i && date_end;
        mon_end  = (mon_q >= 5'h12);
        year_adv = mon_adv && mon_end;
        year_end = (year_q >= 8'h99);
    end

    // Day of week 1..7
    always_ff @(posedge clk) begin
        if (!rst_n)
            wday_q <= 3'd1;
        else if (wr_en_i && (wr_field_i == FLD_WDAY))
            wday_q <= wr_data_i[2:0];
        else if (day_i)
            wday_q <= (wday_q >= 3'd7) ? 3'd1 : wday_q + 3'd1;
    end

    // Date of month
    always_ff @(posedge clk) begin
        if (!rst_n)
            date_q <= 6'h01;
        else if (wr_en_i && (wr_field_i == FLD_DATE))
            date_q <= wr_data_i[5:0];
        else if (day_i)
            date_q <= date_end ? 6'h01 : 6'(bcd_step(8'(date_q)));
    end

    // Month and century flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q  <= 5'h01;
            cent_q <= 1'b0;
        end else if (wr_en_i && (wr_field_i == FLD_MONTH)) begin
            mon_q  <= wr_data_i[4:0];
            cent_q <= wr_data_i[7];
        end else begin
            if (mon_adv)
                mon_q <= mon_end ? 5'h01 : 5'(bcd_step(8'(mon_q)));
            if (year_adv && year_end)
                cent_q <= ~cent_q;
        end
    end

    // Two-digit year
    always_ff @(posedge clk) begin
        if (!rst_n)
            year_q <= 8'h00;
        else if (wr_en_i && (wr_field_i == FLD_YEAR))
            year_q <= wr_data_i;
        else if (year_adv)
            year_q <= year_end ? 8'h00 : bcd_step(year_q);
    end

    // Zero-extended output bytes
    always_comb begin
        wday_o  = {5'd0, wday_q};
        date_o  = {2'd0, date_q};
        month_o = {cent_q, 2'b00, mon_q};
        year_o  = year_q;
    end
endmodule

// File: rtl/bcd_calendar_clock.sv
// Top level: prescaler, time-of-day and date chains, and the write port.
// A seconds write clears the prescaler; halt stops the divider.
module bcd_calendar_clock #(
    parameter int PRESC_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick_i,
    input  logic       osc_halt_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_field_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       half_sec_o
);
    import cal_pkg::*;

    logic sec_tick, day_adv, sec_clear;

    // Seconds write restarts the sub-second chain
    always_comb sec_clear = wr_en_i && (wr_field_i == FLD_SEC);

    cal_prescaler #(.W(PRESC_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (osc_tick_i),
        .run_i     (!osc_halt_i),
        .clear_i   (sec_clear),
        .sec_tick_o(sec_tick),
        .phase_o   (half_sec_o)
    );

    cal_time_of_day u_tod (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (sec_tick),
        .wr_en_i   (wr_en_i),
        .wr_field_i(wr_field_i),
        .wr_data_i (wr_data_i[6:0]),
        .sec_o     (sec_o),
        .min_o     (min_o),
        .hour_o    (hour_o),
        .day_adv_o (day_adv)
    );

    cal_date u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_i     (day_adv),
        .wr_en_i   (wr_en_i),
        .wr_field_i(wr_field_i),
        .wr_data_i (wr_data_i),
        .wday_o    (wday_o),
        .date_o    (date_o),
        .month_o   (month_o),
        .year_o    (year_o)
    );
endmodule

// Property checker for bcd_calendar_clock; bound below.
// Assumes only legal BCD values are written.
module cal_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_tick_i,
    input logic       osc_halt_i,
    input logic       wr_en_i,
    input logic [2:0] wr_field_i,
    input logic [7:0] sec_o,
    input logic [6:0] hour_o,
    input logic [7:0] wday_o,
    input logic [7:0] date_o,
    input logic [4:0] month_o,
    input logic       half_sec_o
);
    assert_sec_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[3:0] <= 4'd9) && (sec_o[7:4] <= 4'd5));

    assert_sec_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_o) |-> ($past(osc_tick_i) || $past(wr_en_i)));

    assert_hour24_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hour_o[6] |-> (hour_o[5:0] <= 6'h23));

    assert_hour12_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hour_o[6] |-> ((hour_o[4:0] >= 5'h01) && (hour_o[4:0] <= 5'h12)
                       && (hour_o[3:0] <= 4'd9)));

    assert_date_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (date_o >= 8'h01) && (date_o <= 8'h31));

    assert_month_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (month_o >= 5'h01) && (month_o <= 5'h12));

    assert_wday_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wday_o >= 8'd1) && (wday_o <= 8'd7));

    assert_clear_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_field_i == 3'd0)) |=> !half_sec_o);

    assert_phase_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_sec_o) |-> ($past(osc_tick_i) && !$past(osc_halt_i)));

    assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_halt_i && !wr_en_i) |=> ($stable(sec_o) && $stable(hour_o)
                                      && $stable(date_o) && $stable(half_sec_o)));
endmodule

bind bcd_calendar_clock cal_checker u_cal_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick_i (osc_tick_i),
    .osc_halt_i (osc_halt_i),
    .wr_en_i    (wr_en_i),
    .wr_field_i (wr_field_i),
    .sec_o      (sec_o),
    .hour_o     (hour_o[6:0]),
    .wday_o     (wday_o),
    .date_o     (date_o),
    .month_o    (month_o[4:0]),
    .half_sec_o (half_sec_o)
);

// File: tb/tb_bcd_calendar_clock.sv
// Self-checking bench: integer time/date model converted to BCD.
module tb_bcd_calendar_clock;
    localparam int PW      = 3;
    localparam int SEC_CYC = 1 << PW;
    localparam int HALF    = SEC_CYC / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       osc_halt = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_field = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;
    logic       half_sec_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int ms, mm, mh, mwd, md, mmo, my, mcen;
    bit m12;

    always #2 clk = ~clk;

    bcd_calendar_clock #(.PRESC_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick), .osc_halt_i(osc_halt),
        .wr_en_i(wr_en), .wr_field_i(wr_field), .wr_data_i(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .half_sec_o(half_sec_o)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] hour_byte(input bit mode12, input int h24);
        int h12;
        if (!mode12) return to_bcd(h24);
        h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
        return 8'h40 | ((h24 >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
    endfunction

    function automatic int dim(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] month_byte(input int mo, input int cen);
        return ((cen != 0) ? 8'h80 : 8'h00) | to_bcd(mo);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "sec",   sec_o,   to_bcd(ms));
        chk(req, "min",   min_o,   to_bcd(mm));
        chk(req, "hour",  hour_o,  hour_byte(m12, mh));
        chk(req, "wday",  wday_o,  to_bcd(mwd));
        chk(req, "date",  date_o,  to_bcd(md));
        chk(req, "month", month_o, month_byte(mmo, mcen));
        chk(req, "year",  year_o,  to_bcd(my));
    endtask

    task automatic model_step();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mwd = (mwd == 7) ? 1 : mwd + 1;
                    md++;
                    if (md > dim(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1; my++;
                            if (my == 100) begin my = 0; mcen ^= 1; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic wr(input logic [2:0] f, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_field = f; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Load all fields with the enable low, seconds last, then run
    task automatic load(input bit mode12, input int h, input int m, input int s,
                        input int wd, input int d, input int mo, input int y,
                        input int cen);
        @(negedge clk);
        osc_tick = 1'b0;
        m12 = mode12; mh = h; mm = m; ms = s; mwd = wd; md = d; mmo = mo;
        my = y; mcen = cen;
        wr(3'd2, hour_byte(mode12, h));
        wr(3'd1, to_bcd(m));
        wr(3'd3, to_bcd(wd));
        wr(3'd4, to_bcd(d));
        wr(3'd5, month_byte(mo, cen));
        wr(3'd6, to_bcd(y));
        wr(3'd0, to_bcd(s));
        check_all("R9");
        osc_tick = 1'b1;
    endtask

    task automatic step1(input string req);
        repeat (SEC_CYC) @(negedge clk);
        model_step();
        check_all(req);
    endtask

    initial begin
        int yrs[4] = '{0, 23, 24, 99};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        m12 = 0; mh = 0; mm = 0; ms = 0; mwd = 1; md = 1; mmo = 1; my = 0; mcen = 0;
        check_all("R1");
        chk("R1", "phase", {7'd0, half_sec_o}, 8'h00);

        // R7 / R8: end of year 99 at midnight, 24-hour mode
        load(0, 23, 59, 58, 7, 31, 12, 99, 0);
        step1("R3");
        step1("R7");
        chk("R8", "wday", wday_o, 8'h01);
        chk("R7", "century", month_o, 8'h81);
        step1("R2");

        // R4: 12-hour sequence
        load(1, 11, 59, 58, 2, 5, 5, 30, 0);
        step1("R4");
        step1("R4");
        chk("R4", "noon", hour_o, 8'h72);
        load(1, 12, 59, 59, 2, 5, 5, 30, 0);
        step1("R4");
        chk("R4", "one_pm", hour_o, 8'h61);
        load(1, 23, 59, 59, 5, 10, 3, 20, 0);
        step1("R4");
        chk("R4", "midnight", hour_o, 8'h52);
        chk("R8", "wday_12h", wday_o, 8'h06);

        // Hour sweep in both modes
        for (int mode = 0; mode < 2; mode++)
            for (int h = 0; h < 24; h++) begin
                load(mode[0], h, 59, 59, 3, 15, 6, 10, 0);
                step1(mode ? "R4" : "R3");
            end

        // Month-end sweep over several years
        foreach (yrs[i]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                load(0, 23, 59, 59, 2, dim(mo, yrs[i]), mo, yrs[i], 0);
                step1((mo == 2) ? "R6" : (mo == 12) ? "R7" : "R5");
            end
            load(0, 23, 59, 59, 2, 28, 2, yrs[i], 0);
            step1("R6");
        end

        // Seconds/minutes sweep
        load(0, 0, 0, 0, 1, 1, 1, 0, 0);
        for (int k = 0; k < 3700; k++) step1("R2");

        // R10 / R11: seconds write mid-second restarts the divider
        load(0, 4, 5, 6, 4, 7, 8, 9, 0);
        repeat (5) @(negedge clk);
        wr(3'd0, 8'h30);
        ms = 30;
        chk("R10", "sec_loaded", sec_o, 8'h30);
        chk("R11", "phase_after_write", {7'd0, half_sec_o}, 8'h00);
        repeat (HALF - 1) @(negedge clk);
        chk("R11", "phase_early", {7'd0, half_sec_o}, 8'h00);
        @(negedge clk);
        chk("R11", "phase_half", {7'd0, half_sec_o}, 8'h01);
        repeat (HALF - 1) @(negedge clk);
        chk("R10", "sec_not_yet", sec_o, 8'h30);
        @(negedge clk);
        model_step();
        check_all("R10");
        chk("R11", "phase_wrap", {7'd0, half_sec_o}, 8'h00);

        // R12: halt freezes everything
        osc_halt = 1'b1;
        wr(3'd0, 8'h10);
        ms = 10;
        repeat (40) @(negedge clk);
        check_all("R12");
        chk("R12", "phase_halt", {7'd0, half_sec_o}, 8'h00);
        osc_halt = 1'b0;
        step1("R12");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule